// File: doc/BRIEF.md
# Operand Specifier Address Decoder

This block sits after the opcode stage of a variable-length instruction decoder running in 32-bit addressing mode. It takes the bytes that specify a memory or register operand, one byte per cycle over a valid/ready handshake. The first byte is the mode byte. An optional scaled-index byte may follow it, and after that an optional 8-bit or 32-bit displacement. The block works out from each byte how many more bytes belong to the operand. When the operand is complete, it emits a one-cycle done pulse.

The done pulse carries one of two results. For a register-direct operand, it gives the register number. For a memory operand, it gives the effective address. The address is computed from a register file snapshot that is sampled in the cycle the final byte is accepted. The pulse also carries the 3-bit reg field of the mode byte and the number of bytes consumed, from 1 to 6. The cycle that shows done can already accept the mode byte of the next operand.

Top module: `osd_addr_decoder`

## Requirements
- R1: During reset `in_ready` and `done_o` are 0. From the first clock edge after reset is released, `in_ready` is 1 and stays 1.
- R2: The mode byte is split as mode = bits 7:6, reg = bits 5:3 and rm = bits 2:0. Mode 3 completes the operand on that byte with `is_reg_o`=1, `reg_num_o`=rm, `ea_o`=0 and `byte_cnt_o`=1.
- R3: Mode 0 with rm other than 4 and 5 completes on the mode byte with `ea_o` = register[rm] and `byte_cnt_o`=1.
- R4: Mode 1 with rm other than 4 is followed by one displacement byte. That byte is sign-extended and added to register[rm]. Register 5 is used as the base when rm=5. `byte_cnt_o`=2.
- R5: Mode 2 with rm other than 4 is followed by a 32-bit displacement, received least significant byte first. `ea_o` = register[rm] + displacement and `byte_cnt_o`=5.
- R6: Mode 0 with rm=5 uses no base register. Four displacement bytes follow, and `ea_o` equals that displacement. `byte_cnt_o`=5.
- R7: rm=4 with mode other than 3 means a scaled-index byte follows, split as scale = bits 7:6, index = bits 5:3 and base = bits 2:0. `ea_o` = register[base] + (register[index] << scale) + displacement. The displacement length follows the mode as in R4/R5, and `byte_cnt_o` is 2, 3 or 6.
- R8: An index field of 4 adds no index term.
- R9: With mode 0, a base field of 5 drops the base register and adds a 32-bit displacement. `byte_cnt_o`=6.
- R10: `done_o` is high for exactly the cycle after the final byte is accepted, and never earlier in the operand. Idle cycles between bytes do not change the result. `reg_field_o` gives the reg field of the mode byte. The register snapshot is the one present in the final byte's cycle.
- R11: A new mode byte is accepted in the same cycle in which `done_o` reports the previous operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Operand specifier byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| regs_i | input | 256 | Register snapshot, register n in bits n*32 +: 32 |
| done_o | output | 1 | One-cycle pulse: operand complete |
| ea_o | output | 32 | Effective address (0 for register-direct) |
| is_reg_o | output | 1 | Operand is register-direct |
| reg_num_o | output | 3 | rm field of the mode byte (register number when direct) |
| reg_field_o | output | 3 | reg field of the mode byte |
| byte_cnt_o | output | 3 | Bytes consumed by the operand, 1 to 6 |

## Verification
Two things can fall in one cycle: the done pulse that reports one operand, and the acceptance of the next operand's mode byte. The bench provokes this by keeping `in_valid` high across a one-byte register-direct operand and a following register-indirect operand. It then checks that both results appear in consecutive cycles, each with its own count and register, and that the second is not lost. A separate scenario changes the register snapshot between the mode byte and the final displacement byte, and expects the address built from the later values.

// File: rtl/osd_pkg.sv
package osd_pkg;

   typedef enum logic [1:0] {
      ST_MODE = 2'd0,
      ST_SIB  = 2'd1,
      ST_DISP = 2'd2
   } osd_state_e;

   typedef enum logic [1:0] {
      DL_NONE = 2'd0,
      DL_BYTE = 2'd1,
      DL_WORD = 2'd2
   } osd_dlen_e;

   localparam logic [1:0] MODE_DIRECT = 2'd3;
   localparam logic [2:0] CODE_ESC    = 3'd4;
   localparam logic [2:0] CODE_FRAME  = 3'd5;

endpackage

// File: rtl/osd_mode_dec.sv
module osd_mode_dec
   import osd_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic [2:0] rm_i,
   output logic       direct_o,
   output logic       sib_o,
   output logic       base_en_o,
   output osd_dlen_e  dlen_o
);
   always_comb begin
      direct_o  = (mode_i == MODE_DIRECT);
      sib_o     = !direct_o && (rm_i == CODE_ESC);
      base_en_o = !((mode_i == 2'd0) && (rm_i == CODE_FRAME));
      unique case (mode_i)
         2'd1:    dlen_o = DL_BYTE;
         2'd2:    dlen_o = DL_WORD;
         2'd0:    dlen_o = (rm_i == CODE_FRAME) ? DL_WORD : DL_NONE;
         default: dlen_o = DL_NONE;
      endcase
   end
endmodule

// File: rtl/osd_sib_dec.sv
module osd_sib_dec
   import osd_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic [2:0] index_i,
   input  logic [2:0] base_i,
   output logic       idx_en_o,
   output logic       base_en_o,
   output osd_dlen_e  dlen_o
);
   always_comb begin
      idx_en_o  = (index_i != CODE_ESC);
      base_en_o = !((mode_i == 2'd0) && (base_i == CODE_FRAME));
      unique case (mode_i)
         2'd1:    dlen_o = DL_BYTE;
         2'd2:    dlen_o = DL_WORD;
         2'd0:    dlen_o = (base_i == CODE_FRAME) ? DL_WORD : DL_NONE;
         default: dlen_o = DL_NONE;
      endcase
   end
endmodule

// File: rtl/osd_ea_calc.sv
module osd_ea_calc #(
   parameter int ADDR_W = 32,
   parameter int NREG   = 8,
   localparam int SEL_W = $clog2(NREG)
) (
   input  logic [NREG*ADDR_W-1:0] regs_i,
   input  logic                   base_en_i,
   input  logic [SEL_W-1:0]       base_sel_i,
   input  logic                   idx_en_i,
   input  logic [SEL_W-1:0]       idx_sel_i,
   input  logic [1:0]             scale_i,
   input  logic [ADDR_W-1:0]      disp_i,
   output logic [ADDR_W-1:0]      ea_o
);
   logic [ADDR_W-1:0] rf [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_unpack
      assign rf[g] = regs_i[g*ADDR_W +: ADDR_W];
   end

   logic [ADDR_W-1:0] base_term, idx_term;

   always_comb begin
      base_term = base_en_i ? rf[base_sel_i] : '0;
      idx_term  = idx_en_i ? (rf[idx_sel_i] << scale_i) : '0;
      ea_o      = base_term + idx_term + disp_i;
   end
endmodule

// File: rtl/osd_addr_decoder.sv
module osd_addr_decoder
   import osd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NREG   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [7:0]             in_byte,
   output logic                   in_ready,
   input  logic [NREG*ADDR_W-1:0] regs_i,
   output logic                   done_o,
   output logic [ADDR_W-1:0]      ea_o,
   output logic                   is_reg_o,
   output logic [2:0]             reg_num_o,
   output logic [2:0]             reg_field_o,
   output logic [2:0]             byte_cnt_o
);
   localparam int DISP_BYTES = ADDR_W / 8;
   localparam int LEFT_W     = $clog2(DISP_BYTES + 1);
   localparam int SEL_W      = $clog2(NREG);

   if (ADDR_W != 32) begin : g_bad_width
      $error("osd_addr_decoder: ADDR_W must be 32");
   end
   if (NREG != 8) begin : g_bad_nreg
      $error("osd_addr_decoder: NREG must be 8 (3-bit register fields)");
   end

   osd_state_e        state_q, state_n;
   logic              ready_q;
   logic [1:0]        mode_q;
   logic [2:0]        reg_q, rm_q;
   logic              base_en_q, idx_en_q;
   logic [SEL_W-1:0]  base_sel_q, idx_sel_q;
   logic [1:0]        scale_q;
   logic [LEFT_W-1:0] left_q, left_n;
   logic              is8_q, is8_n;
   logic [2:0]        cnt_q, cnt_n;
   logic [ADDR_W-1:0] disp_q, disp_shift;

   logic              acc, fin, direct_n;
   logic [2:0]        rfield_n, rnum_n;
   logic              r_base_en, r_idx_en;
   logic [SEL_W-1:0]  r_base_sel, r_idx_sel;
   logic [1:0]        r_scale;
   logic [ADDR_W-1:0] r_disp, ea_w;

   logic              m_direct, m_sib, m_base_en;
   osd_dlen_e         m_dlen;
   logic              s_idx_en, s_base_en;
   osd_dlen_e         s_dlen;

   assign in_ready = ready_q;
   assign acc      = in_valid && ready_q;

   osd_mode_dec i_mode_dec (
      .mode_i    (in_byte[7:6]),
      .rm_i      (in_byte[2:0]),
      .direct_o  (m_direct),
      .sib_o     (m_sib),
      .base_en_o (m_base_en),
      .dlen_o    (m_dlen)
   );

   osd_sib_dec i_sib_dec (
      .mode_i    (mode_q),
      .index_i   (in_byte[5:3]),
      .base_i    (in_byte[2:0]),
      .idx_en_o  (s_idx_en),
      .base_en_o (s_base_en),
      .dlen_o    (s_dlen)
   );

   osd_ea_calc #(.ADDR_W(ADDR_W), .NREG(NREG)) i_ea_calc (
      .regs_i     (regs_i),
      .base_en_i  (r_base_en),
      .base_sel_i (r_base_sel),
      .idx_en_i   (r_idx_en),
      .idx_sel_i  (r_idx_sel),
      .scale_i    (r_scale),
      .disp_i     (r_disp),
      .ea_o       (ea_w)
   );

   always_comb begin
      disp_shift = {in_byte, disp_q[ADDR_W-1:8]};
      state_n    = state_q;
      fin        = 1'b0;
      direct_n   = 1'b0;
      left_n     = left_q;
      is8_n      = is8_q;
      cnt_n      = cnt_q + 3'd1;
      rfield_n   = reg_q;
      rnum_n     = rm_q;
      r_base_en  = base_en_q;
      r_base_sel = base_sel_q;
      r_idx_en   = idx_en_q;
      r_idx_sel  = idx_sel_q;
      r_scale    = scale_q;
      r_disp     = is8_q ? {{(ADDR_W-8){in_byte[7]}}, in_byte} : disp_shift;
      unique case (state_q)
         ST_MODE: begin
            cnt_n      = 3'd1;
            rfield_n   = in_byte[5:3];
            rnum_n     = in_byte[2:0];
            r_base_en  = m_base_en;
            r_base_sel = in_byte[2:0];
            r_idx_en   = 1'b0;
            r_idx_sel  = '0;
            r_scale    = 2'd0;
            r_disp     = '0;
            if (m_direct) begin
               fin      = 1'b1;
               direct_n = 1'b1;
            end else if (m_sib) begin
               state_n = ST_SIB;
            end else if (m_dlen == DL_NONE) begin
               fin = 1'b1;
            end else begin
               state_n = ST_DISP;
               is8_n   = (m_dlen == DL_BYTE);
               left_n  = (m_dlen == DL_BYTE) ? LEFT_W'(1) : LEFT_W'(DISP_BYTES);
            end
         end
         ST_SIB: begin
            r_base_en  = s_base_en;
            r_base_sel = in_byte[2:0];
            r_idx_en   = s_idx_en;
            r_idx_sel  = in_byte[5:3];
            r_scale    = in_byte[7:6];
            r_disp     = '0;
            if (s_dlen == DL_NONE) begin
               fin = 1'b1;
            end else begin
               state_n = ST_DISP;
               is8_n   = (s_dlen == DL_BYTE);
               left_n  = (s_dlen == DL_BYTE) ? LEFT_W'(1) : LEFT_W'(DISP_BYTES);
            end
         end
         default: begin
            left_n = left_q - LEFT_W'(1);
            if (left_q == LEFT_W'(1)) fin = 1'b1;
         end
      endcase
      if (fin) state_n = ST_MODE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_MODE;
         ready_q     <= 1'b0;
         mode_q      <= '0;
         reg_q       <= '0;
         rm_q        <= '0;
         base_en_q   <= 1'b0;
         base_sel_q  <= '0;
         idx_en_q    <= 1'b0;
         idx_sel_q   <= '0;
         scale_q     <= '0;
         left_q      <= '0;
         is8_q       <= 1'b0;
         cnt_q       <= '0;
         disp_q      <= '0;
         done_o      <= 1'b0;
         ea_o        <= '0;
         is_reg_o    <= 1'b0;
         reg_num_o   <= '0;
         reg_field_o <= '0;
         byte_cnt_o  <= '0;
      end else begin
         ready_q <= 1'b1;
         done_o  <= acc && fin;
         if (acc) begin
            state_q    <= state_n;
            base_en_q  <= r_base_en;
            base_sel_q <= r_base_sel;
            idx_en_q   <= r_idx_en;
            idx_sel_q  <= r_idx_sel;
            scale_q    <= r_scale;
            left_q     <= left_n;
            is8_q      <= is8_n;
            cnt_q      <= cnt_n;
            disp_q     <= disp_shift;
            if (state_q == ST_MODE) begin
               mode_q <= in_byte[7:6];
               reg_q  <= in_byte[5:3];
               rm_q   <= in_byte[2:0];
            end
            if (fin) begin
               ea_o        <= direct_n ? '0 : ea_w;
               is_reg_o    <= direct_n;
               reg_num_o   <= rnum_n;
               reg_field_o <= rfield_n;
               byte_cnt_o  <= cnt_n;
            end
         end
      end
   end

   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> in_ready); // R1
   AST_DIRECT_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && is_reg_o) |-> (byte_cnt_o == 3'd1)); // R2
   AST_DIRECT_FROM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && is_reg_o) |-> ($past(in_byte[7:6]) == MODE_DIRECT)); // R2
   AST_COUNT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (byte_cnt_o >= 3'd1 && byte_cnt_o <= 3'd6)); // R9
   AST_DONE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(in_valid && in_ready)); // R10
endmodule

// File: tb/test_osd_addr_decoder.sv
module test_osd_addr_decoder;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   in_byte = 8'h00;
   logic         in_ready;
   logic [255:0] regs_i;
   logic         done_o;
   logic [31:0]  ea_o;
   logic         is_reg_o;
   logic [2:0]   reg_num_o, reg_field_o, byte_cnt_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic [7:0] sq [0:5];

   always #2.5 clk = ~clk;

   osd_addr_decoder i_osd_addr_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .regs_i(regs_i), .done_o(done_o), .ea_o(ea_o),
      .is_reg_o(is_reg_o), .reg_num_o(reg_num_o), .reg_field_o(reg_field_o),
      .byte_cnt_o(byte_cnt_o)
   );

   function automatic logic [31:0] rv(input int i);
      return 32'h0A00_0000 + (i << 12) + i * 3;
   endfunction

   task automatic load_regs();
      for (int i = 0; i < 8; i++) regs_i[i*32 +: 32] = rv(i);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Feeds n bytes from sq with gap idle cycles between them; ends at the
   // falling edge after the final byte was accepted.
   task automatic run_spec(input int n, input int gap, input string tag);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1;
         in_byte  = sq[i];
         @(negedge clk);
         in_valid = 1'b0;
         if (i < n - 1) begin
            chk(!done_o, {tag, " R10 early done"}, 32'(done_o), 32'd0);
            for (int k = 0; k < gap; k++) begin
               @(negedge clk);
               chk(!done_o, {tag, " R10 done in gap"}, 32'(done_o), 32'd0);
            end
         end
      end
   endtask

   task automatic expect_mem(input string tag, input logic [31:0] ea,
                             input logic [2:0] cnt, input logic [2:0] rf);
      chk(done_o === 1'b1, {tag, " done"}, 32'(done_o), 32'd1);
      chk(is_reg_o === 1'b0, {tag, " is_reg"}, 32'(is_reg_o), 32'd0);
      chk(ea_o === ea, {tag, " ea"}, ea_o, ea);
      chk(byte_cnt_o === cnt, {tag, " count"}, 32'(byte_cnt_o), 32'(cnt));
      chk(reg_field_o === rf, {tag, " R10 reg field"}, 32'(reg_field_o), 32'(rf));
      @(negedge clk);
      chk(done_o === 1'b0, {tag, " R10 single pulse"}, 32'(done_o), 32'd0);
   endtask

   task automatic t_reset();
      chk(in_ready === 1'b0, "R1 ready in reset", 32'(in_ready), 32'd0);
      chk(done_o === 1'b0, "R1 done in reset", 32'(done_o), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);
      chk(done_o === 1'b0, "R1 done after reset", 32'(done_o), 32'd0);
   endtask

   task automatic t_direct();
      sq[0] = 8'hD6; // mode 3, reg 2, rm 6
      run_spec(1, 0, "R2");
      chk(done_o === 1'b1, "R2 done", 32'(done_o), 32'd1);
      chk(is_reg_o === 1'b1, "R2 is_reg", 32'(is_reg_o), 32'd1);
      chk(reg_num_o === 3'd6, "R2 reg num", 32'(reg_num_o), 32'd6);
      chk(reg_field_o === 3'd2, "R2 reg field", 32'(reg_field_o), 32'd2);
      chk(ea_o === 32'd0, "R2 ea zero", ea_o, 32'd0);
      chk(byte_cnt_o === 3'd1, "R2 count", 32'(byte_cnt_o), 32'd1);
      @(negedge clk);
   endtask

   task automatic t_indirect();
      sq[0] = 8'h0B; // mode 0, reg 1, rm 3
      run_spec(1, 0, "R3");
      expect_mem("R3", rv(3), 3'd1, 3'd1);
   endtask

   task automatic t_disp8();
      sq[0] = 8'h41; sq[1] = 8'hF0; // mode 1, rm 1, disp -16
      run_spec(2, 0, "R4 neg");
      expect_mem("R4 neg", rv(1) - 32'd16, 3'd2, 3'd0);
      sq[0] = 8'h7D; sq[1] = 8'h04; // mode 1, reg 7, rm 5 (frame reg) +4
      run_spec(2, 1, "R4 frame");
      expect_mem("R4 frame", rv(5) + 32'd4, 3'd2, 3'd7);
   endtask

   task automatic t_disp32();
      sq[0] = 8'h87; sq[1] = 8'h78; sq[2] = 8'h56; sq[3] = 8'h34; sq[4] = 8'h12;
      run_spec(5, 0, "R5");
      expect_mem("R5", rv(7) + 32'h1234_5678, 3'd5, 3'd0);
   endtask

   task automatic t_absolute();
      sq[0] = 8'h1D; sq[1] = 8'hEF; sq[2] = 8'hBE; sq[3] = 8'hAD; sq[4] = 8'hDE;
      run_spec(5, 0, "R6");
      expect_mem("R6", 32'hDEAD_BEEF, 3'd5, 3'd3);
   endtask

   task automatic t_sib();
      sq[0] = 8'h04; sq[1] = 8'h8B; // scale 2, index 1, base 3
      run_spec(2, 0, "R7 mode0");
      expect_mem("R7 mode0", rv(3) + (rv(1) << 2), 3'd2, 3'd0);
      sq[0] = 8'h44; sq[1] = 8'hF0; sq[2] = 8'h80; // scale 3, index 6, base 0, -128
      run_spec(3, 0, "R7 mode1");
      expect_mem("R7 mode1", rv(0) + (rv(6) << 3) - 32'd128, 3'd3, 3'd0);
      sq[0] = 8'h84; sq[1] = 8'h15; // mode 2, scale 0, index 2, base 5 (kept)
      sq[2] = 8'h01; sq[3] = 8'h02; sq[4] = 8'h03; sq[5] = 8'h04;
      run_spec(6, 0, "R7 mode2");
      expect_mem("R7 mode2", rv(5) + rv(2) + 32'h0403_0201, 3'd6, 3'd0);
   endtask

   task automatic t_noindex();
      sq[0] = 8'h24; sq[1] = 8'hE7; // reg 4, scale 3, index 4, base 7
      run_spec(2, 0, "R8");
      expect_mem("R8", rv(7), 3'd2, 3'd4);
   endtask

   task automatic t_nobase();
      sq[0] = 8'h04; sq[1] = 8'h45; // scale 1, index 0, base 5 in mode 0
      sq[2] = 8'h10; sq[3] = 8'h00; sq[4] = 8'h00; sq[5] = 8'h00;
      run_spec(6, 0, "R9 index");
      expect_mem("R9 index", (rv(0) << 1) + 32'h10, 3'd6, 3'd0);
      sq[0] = 8'h04; sq[1] = 8'h25; // index 4, base 5: displacement only
      sq[2] = 8'h44; sq[3] = 8'h33; sq[4] = 8'h22; sq[5] = 8'h11;
      run_spec(6, 2, "R9 bare");
      expect_mem("R9 bare", 32'h1122_3344, 3'd6, 3'd0);
   endtask

   task automatic t_snapshot();
      in_valid = 1'b1; in_byte = 8'h72; // mode 1, reg 6, rm 2
      @(negedge clk);
      in_valid = 1'b0;
      chk(!done_o, "R10 early done", 32'(done_o), 32'd0);
      regs_i[2*32 +: 32] = 32'h5000_0000;
      repeat (3) begin
         @(negedge clk);
         chk(!done_o, "R10 stall", 32'(done_o), 32'd0);
      end
      in_valid = 1'b1; in_byte = 8'h08;
      @(negedge clk);
      in_valid = 1'b0;
      regs_i[2*32 +: 32] = 32'h7000_0000;
      expect_mem("R10 snapshot", 32'h5000_0008, 3'd2, 3'd6);
      load_regs();
   endtask

   task automatic t_back_to_back();
      in_valid = 1'b1; in_byte = 8'hD6;
      @(negedge clk);
      in_byte = 8'h0B;
      chk(done_o === 1'b1 && is_reg_o === 1'b1, "R11 first done",
          {30'd0, done_o, is_reg_o}, 32'd3);
      chk(reg_num_o === 3'd6, "R11 first reg", 32'(reg_num_o), 32'd6);
      @(negedge clk);
      in_valid = 1'b0;
      chk(done_o === 1'b1 && is_reg_o === 1'b0, "R11 second done",
          {30'd0, done_o, is_reg_o}, 32'd2);
      chk(ea_o === rv(3), "R11 second ea", ea_o, rv(3));
      chk(byte_cnt_o === 3'd1, "R11 second count", 32'(byte_cnt_o), 32'd1);
      @(negedge clk);
      chk(done_o === 1'b0, "R11 pulse ends", 32'(done_o), 32'd0);
   endtask

   initial begin
      load_regs();
      @(negedge clk);
      t_reset();
      t_direct();
      t_indirect();
      t_disp8();
      t_disp32();
      t_absolute();
      t_sib();
      t_noindex();
      t_nobase();
      t_snapshot();
      t_back_to_back();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule